// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins. Each pin is first passed through a two-stage synchroniser. A programmable per-pin detector then turns edges or active levels into events. Events are latched in a pending register. A pending pin signals only when it is unmasked and its priority field is nonzero. Qualified pins are OR-ed into one combined interrupt. They are also presented on per-pin outputs, but only when the individual-routing mode bit is set.

Software reaches the block over a plain register bus. The bus has a write strobe, a 3-bit word address, 32-bit write data and a combinational read-data path. The registers are: sense configuration, priority, pending source, write-only mask-set, write-only mask-clear, and a control word that carries the routing mode bit. Pins are packed from the most significant end in every register.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every pin is masked and no pin is pending. All sense and priority fields read 0, the control word reads 0, and both interrupt outputs are low.
- R2: Address 0 is the sense register. Pin n uses the SENSE_W-bit field whose top bit is 31-n*SENSE_W. The register reads back exactly as written.
- R3: Each pin crosses two synchronising flops and then an edge-history flop. An event caused by a pin change made between two rising edges shows in the source register, and at the outputs, after the third following rising edge.
- R4: Sense code 0 sets pending on a falling edge, code 1 on a rising edge, and code 4 on either edge. Each edge sets pending once.
- R5: Sense code 2 (pin low) and code 3 (pin high) re-assert pending on every cycle the level holds. A clear written while the level is active leaves the bit set.
- R6: A sense code above 4 never sets pending.
- R7: Address 2 is the source register, with pin k at bit 7-k. A write clears each pin whose bit is 0 and keeps each pin whose bit is 1. An event in the same cycle as a clear wins.
- R8: A 1 written to bit 7-k of address 3 masks pin k. A 1 written to bit 7-k of address 4 unmasks pin k. A 0 bit has no effect. Both addresses read as 0.
- R9: Address 1 is the priority register, with a 4-bit field for pin n whose top bit is 31-4n. A field of 0 blocks the pin, and any nonzero field lets it through.
- R10: Per-pin output k is high when pin k is pending, unmasked and has nonzero priority. This holds only while bit 23 of the control word (address 5) is set. When that bit is clear, all per-pin outputs are 0.
- R11: The combined output is the OR of the qualified pins, whatever the mode bit is. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw external interrupt pins, bit k = pin k |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Combinational read data for addr |
| irqAny | output | 1 | Combined interrupt |
| irqPin | output | NUM_PINS | Per-pin interrupt outputs |

## Verification
The assertions assume reset is applied before any check and that pins and bus signals are stable around each rising clock edge. The pin inputs are asynchronous in use, but are sampled only through the synchroniser. The stimulus drives every input on the falling edge, so each input is sampled cleanly once per cycle. The directed phase keeps writes one cycle apart so each register effect can be seen alone. The random phase writes to any address, including unmapped ones and illegal sense codes, and a behavioural model follows it.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int PIN_MAX = 8;

  typedef enum logic [2:0] {
    REG_SENSE  = 3'd0,
    REG_PRIO   = 3'd1,
    REG_SOURCE = 3'd2,
    REG_MSET   = 3'd3,
    REG_MCLR   = 3'd4,
    REG_CTRL   = 3'd5
  } regSel_e;

  typedef enum logic [3:0] {
    SNS_FALL = 4'd0,
    SNS_RISE = 4'd1,
    SNS_LOW  = 4'd2,
    SNS_HIGH = 4'd3,
    SNS_BOTH = 4'd4
  } senseCode_e;

  // strobes from register control to the datapath
  typedef struct packed {
    logic               srcWr;
    logic [PIN_MAX-1:0] keep;   // bit k = pin k keeps its pending state
  } srcStrobe_t;
endpackage

// File: rtl/extint_pin.sv
module extint_pin
  import extint_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pinRaw,
  input  logic [SENSE_W-1:0] senseField,
  output logic               event_o
);
  logic syncA, syncB, histC;
  logic [3:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      histC <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      histC <= syncB;
    end
  end

  assign code = 4'(senseField);

  always_comb begin
    unique case (code)
      SNS_FALL: event_o = histC & ~syncB;
      SNS_RISE: event_o = ~histC & syncB;
      SNS_LOW:  event_o = ~syncB;
      SNS_HIGH: event_o = syncB;
      SNS_BOTH: event_o = histC ^ syncB;
      default:  event_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 8,
  parameter int MODE_BIT = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [2:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pendVec,
  output logic [DATA_W-1:0]   senseReg,
  output logic [DATA_W-1:0]   prioReg,
  output logic [NUM_PINS-1:0] maskVec,
  output logic                modeOn,
  output srcStrobe_t          strb,
  output logic [DATA_W-1:0]   rdData
);
  logic hitSense, hitPrio, hitSrc, hitSet, hitClr, hitCtrl;
  logic [DATA_W-1:0] srcView;

  assign hitSense = wrEn && (addr == REG_SENSE);
  assign hitPrio  = wrEn && (addr == REG_PRIO);
  assign hitSrc   = wrEn && (addr == REG_SOURCE);
  assign hitSet   = wrEn && (addr == REG_MSET);
  assign hitClr   = wrEn && (addr == REG_MCLR);
  assign hitCtrl  = wrEn && (addr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      senseReg <= '0;
      prioReg  <= '0;
      modeOn   <= 1'b0;
    end else begin
      if (hitSense) senseReg <= wrData;
      if (hitPrio)  prioReg  <= wrData;
      if (hitCtrl)  modeOn   <= wrData[MODE_BIT];
    end
  end

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           maskVec[k] <= 1'b1;
      else if (hitSet && wrData[SRC_W-1-k]) maskVec[k] <= 1'b1;
      else if (hitClr && wrData[SRC_W-1-k]) maskVec[k] <= 1'b0;
    end
  end

  assign strb.srcWr = hitSrc;
  for (genvar k = 0; k < PIN_MAX; k++) begin : g_keep
    if (k < NUM_PINS) begin : g_used
      assign strb.keep[k] = wrData[SRC_W-1-k];
    end else begin : g_unused
      assign strb.keep[k] = 1'b1;
    end
  end

  always_comb begin
    srcView = '0;
    for (int k = 0; k < NUM_PINS; k++) srcView[SRC_W-1-k] = pendVec[k];
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      REG_SENSE:  rdData = senseReg;
      REG_PRIO:   rdData = prioReg;
      REG_SOURCE: rdData = srcView;
      REG_CTRL:   rdData[MODE_BIT] = modeOn;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [DATA_W-1:0]   senseReg,
  input  logic [DATA_W-1:0]   prioReg,
  input  logic [NUM_PINS-1:0] maskVec,
  input  logic                modeOn,
  input  srcStrobe_t          strb,
  output logic [NUM_PINS-1:0] pendVec,
  output logic                irqAny,
  output logic [NUM_PINS-1:0] irqPin
);
  logic [NUM_PINS-1:0] evVec, prioOk, gatedVec, keptVec;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    extint_pin #(.SENSE_W(SENSE_W)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .pinRaw     (pinIn[k]),
      .senseField (senseReg[DATA_W-1-k*SENSE_W -: SENSE_W]),
      .event_o    (evVec[k])
    );
    assign prioOk[k] = |prioReg[DATA_W-1-k*PRIO_W -: PRIO_W];
  end

  assign keptVec = strb.srcWr ? (pendVec & strb.keep[NUM_PINS-1:0]) : pendVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendVec <= '0;
    else        pendVec <= keptVec | evVec;
  end

  assign gatedVec = pendVec & ~maskVec & prioOk;
  assign irqAny   = |gatedVec;
  assign irqPin   = modeOn ? gatedVec : '0;
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SENSE_W  = 4,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 8,
  parameter int MODE_BIT = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [2:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqAny,
  output logic [NUM_PINS-1:0] irqPin
);
  logic [DATA_W-1:0]   senseReg, prioReg;
  logic [NUM_PINS-1:0] maskVec, pendVec;
  logic                modeOn;
  srcStrobe_t          strb;

  extint_regs #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .SRC_W(SRC_W), .MODE_BIT(MODE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .pendVec(pendVec), .senseReg(senseReg), .prioReg(prioReg),
    .maskVec(maskVec), .modeOn(modeOn), .strb(strb), .rdData(rdData)
  );

  extint_datapath #(
    .NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .senseReg(senseReg),
    .prioReg(prioReg), .maskVec(maskVec), .modeOn(modeOn), .strb(strb),
    .pendVec(pendVec), .irqAny(irqAny), .irqPin(irqPin)
  );
endmodule

// File: rtl/extint_chk.sv
module extint_chk #(
  parameter int NUM_PINS = 8,
  parameter int PRIO_W   = 4,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          addr,
  input logic [DATA_W-1:0]   rdData,
  input logic                irqAny,
  input logic [NUM_PINS-1:0] irqPin,
  input logic [NUM_PINS-1:0] maskVec,
  input logic [NUM_PINS-1:0] pendVec,
  input logic [DATA_W-1:0]   prioReg,
  input logic                modeOn,
  input logic                srcWr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irqAny && irqPin == '0));

  // R8
  mask_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3 || addr == 3'd4) |-> rdData == '0);

  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modeOn |-> irqPin == '0);

  // R11
  any_matches_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeOn |-> irqAny == (|irqPin));

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    // R8
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      maskVec[k] |-> !irqPin[k]);
    // R9
    prio_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prioReg[DATA_W-1-k*PRIO_W -: PRIO_W] == '0) |-> !irqPin[k]);
    // R7
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pendVec[k]) |-> $past(srcWr));
  end
endmodule

bind extint_ctrl extint_chk #(
  .NUM_PINS(NUM_PINS), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdData(rdData), .irqAny(irqAny),
  .irqPin(irqPin), .maskVec(maskVec), .pendVec(pendVec), .prioReg(prioReg),
  .modeOn(modeOn), .srcWr(strb.srcWr)
);

// File: tb/extint_ctrl_tb.sv
`timescale 1ns/1ps
module extint_ctrl_tb;
  localparam int NP = 8;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqAny;
  logic [NP-1:0] irqPin;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  extint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqAny(irqAny), .irqPin(irqPin)
  );

  // behavioural reference model
  bit m1[NP], m2[NP], m3[NP], mPend[NP], mMask[NP];
  logic [31:0] mSense, mPrio;
  bit mMode;

  function automatic int senseOf(int k);
    return int'((mSense >> (32 - (k + 1) * SW)) & ((32'd1 << SW) - 1));
  endfunction

  function automatic bit prioOf(int k);
    return ((mPrio >> (28 - 4 * k)) & 32'hF) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NP; k++) begin
        m1[k] = 0; m2[k] = 0; m3[k] = 0; mPend[k] = 0; mMask[k] = 1;
      end
      mSense = 0; mPrio = 0; mMode = 0;
    end else begin
      bit ev[NP];
      for (int k = 0; k < NP; k++) begin
        case (senseOf(k))
          0: ev[k] = m3[k] && !m2[k];
          1: ev[k] = !m3[k] && m2[k];
          2: ev[k] = !m2[k];
          3: ev[k] = m2[k];
          4: ev[k] = m3[k] != m2[k];
          default: ev[k] = 0;
        endcase
      end
      for (int k = 0; k < NP; k++) begin
        if (wrEn && addr == 3'd2 && !wrData[7 - k]) mPend[k] = 0;
        if (ev[k]) mPend[k] = 1;
        if (wrEn && addr == 3'd3 && wrData[7 - k]) mMask[k] = 1;
        if (wrEn && addr == 3'd4 && wrData[7 - k]) mMask[k] = 0;
        m3[k] = m2[k]; m2[k] = m1[k]; m1[k] = pinIn[k];
      end
      if (wrEn && addr == 3'd0) mSense = wrData;
      if (wrEn && addr == 3'd1) mPrio = wrData;
      if (wrEn && addr == 3'd5) mMode = wrData[23];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [NP-1:0] g;
      logic [31:0] er;
      for (int k = 0; k < NP; k++) g[k] = mPend[k] && !mMask[k] && prioOf(k);
      chk("R10 per-pin outputs", 32'(irqPin), mMode ? 32'(g) : 32'd0);
      chk("R11 combined output", 32'(irqAny), 32'(|g));
      er = 0;
      case (addr)
        3'd0: er = mSense;
        3'd1: er = mPrio;
        3'd2: for (int k = 0; k < NP; k++) er[7 - k] = mPend[k];
        3'd5: er[23] = mMode;
        default: er = 0;
      endcase
      case (addr)
        3'd0: chk("R2 sense readback", rdData, er);
        3'd1: chk("R9 prio readback", rdData, er);
        3'd2: chk("R7 source readback", rdData, er);
        3'd3, 3'd4: chk("R8 mask regs read zero", rdData, er);
        default: chk("R11 ctrl/unmapped read", rdData, er);
      endcase
    end
  end

  task automatic busWr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; addr = 3'd2;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitCyc(4);
    rst_n = 1'b1;
    waitCyc(1);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      readReg(3'(a), v);
      chk("R1 register reads zero after reset", v, 0);
    end
    chk("R1 combined low after reset", 32'(irqAny), 0);
    chk("R1 per-pin low after reset", 32'(irqPin), 0);
    // R1: all pins start masked; give priority and pending then check outputs stay low
    busWr(3'd5, 32'h0080_0000);
    busWr(3'd1, 32'hFFFF_FFFF);
    busWr(3'd0, 32'h3333_3333);   // all high-level, pins low: nothing
    pinIn = 8'hFF;
    waitCyc(4);
    chk("R1 pins masked after reset", 32'(irqPin), 0);
    pinIn = 8'h00;
    busWr(3'd0, 32'h0123_4711);   // pin0 fall,1 rise,2 low,3 high,4 both,5 illegal,6/7 rise
    busWr(3'd4, 32'h0000_00FF);
    waitCyc(4);
    busWr(3'd2, 32'h0);
    // R3 timing: pin1 rising at bit 6
    pinIn[1] = 1'b1;
    waitCyc(1); readReg(3'd2, v); chk("R3 not seen after 1 edge", 32'(v[6]), 0);
    waitCyc(1); readReg(3'd2, v); chk("R3 not seen after 2 edges", 32'(v[6]), 0);
    waitCyc(1); readReg(3'd2, v); chk("R3 seen after 3 edges", 32'(v[6]), 1);
    chk("R10 pin1 output", 32'(irqPin[1]), 1);
    // R4 falling: pin0 rise must not set, fall must
    busWr(3'd2, 32'h0);
    pinIn[0] = 1'b1; waitCyc(4); readReg(3'd2, v);
    chk("R4 falling mode ignores rise", 32'(v[7]), 0);
    pinIn[0] = 1'b0; waitCyc(4); readReg(3'd2, v);
    chk("R4 falling mode sees fall", 32'(v[7]), 1);
    // R4 both edges on pin4 (bit 3)
    pinIn[4] = 1'b1; waitCyc(4); readReg(3'd2, v);
    chk("R4 both-edge rise", 32'(v[3]), 1);
    busWr(3'd2, 32'h0); readReg(3'd2, v);
    chk("R4 edge clears after write", 32'(v[3]), 0);
    pinIn[4] = 1'b0; waitCyc(4); readReg(3'd2, v);
    chk("R4 both-edge fall", 32'(v[3]), 1);
    // R5 low level on pin2 (bit 5) survives a clear
    busWr(3'd2, 32'h0); readReg(3'd2, v);
    chk("R5 level reasserts over clear", 32'(v[5]), 1);
    pinIn[2] = 1'b1; waitCyc(4); busWr(3'd2, 32'h0); readReg(3'd2, v);
    chk("R5 clear works when level gone", 32'(v[5]), 0);
    // R6 illegal code on pin5 (bit 2)
    pinIn[5] = 1'b1; waitCyc(4); pinIn[5] = 1'b0; waitCyc(4); readReg(3'd2, v);
    chk("R6 illegal sense no pending", 32'(v[2]), 0);
    // R7 keep-on-one: pins 6,7 pending, write FE clears pin7 only
    pinIn[6] = 1'b1; pinIn[7] = 1'b1; waitCyc(4);
    busWr(3'd2, 32'h0000_00FE); readReg(3'd2, v);
    chk("R7 pin6 kept", 32'(v[1]), 1);
    chk("R7 pin7 cleared", 32'(v[0]), 0);
    // R8 mask set / clear on pin6
    busWr(3'd3, 32'h0000_0002);
    chk("R8 masked pin6 silent", 32'(irqPin[6]), 0);
    busWr(3'd4, 32'h0000_0000);
    chk("R8 zero clear no effect", 32'(irqPin[6]), 0);
    busWr(3'd4, 32'h0000_0002);
    chk("R8 unmask restores pin6", 32'(irqPin[6]), 1);
    // R9 priority zero for pin6 (bits 7:4)
    busWr(3'd1, 32'hFFFF_FF0F);
    chk("R9 zero prio blocks pin6", 32'(irqPin[6]), 0);
    busWr(3'd1, 32'hFFFF_FF1F);
    chk("R9 nonzero prio passes pin6", 32'(irqPin[6]), 1);
    // R10/R11 mode bit off
    busWr(3'd5, 32'h0);
    chk("R10 mode off silences pins", 32'(irqPin), 0);
    chk("R11 combined still active", 32'(irqAny), 1);
    busWr(3'd5, 32'h0080_0000);
    // random phase, model compares every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      pinIn = 8'($urandom);
      wrEn = ($urandom % 4) == 0;
      addr = 3'($urandom % 7);
      wrData = $urandom;
    end
    @(negedge clk); wrEn = 1'b0;
    waitCyc(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule